// File: doc/BRIEF.md
# AUX Channel Transaction Register Engine

This block is a memory-mapped engine that carries out one auxiliary-channel request per software trigger. Software fills up to sixteen payload bytes in the write-data words, writes a command word with the request code, the address, the length and an address-only flag, and then sets the start bit. The engine turns the command into a byte stream on a valid/ready link toward a sink. It then waits for a reply stream, or for a programmable timeout, and clears the start bit when it finishes.

Results appear in a status word. Read payload appears in the read-data words. A soft-reset bit holds the engine idle and clears its results. Line coding, sync patterns and the electrical layer are outside this block. The sink sees plain bytes, and the reply comes back as bytes with a last-byte marker.

Top module: `aux_xact_engine`

## Requirements
- R1: After reset, the command word (0x50) and the status word (0x78) read 0. The request/config word (0x74) reads 0x0040_1200: timeout limit 64 in bits 31:16, pulse count 9 in bits 13:9, timer enable (bit 2) clear, sync select (bit 1) clear, busy (bit 0) clear. The reset-control word (0x700) reads 0x10.
- R2: The command word at 0x50 holds the request code in bits 3:0, the length minus one in bits 7:4, a 20-bit address in bits 27:8 and an address-only flag in bit 28. A request is sent in this byte order: {code, address[19:16]}, address[15:8], address[7:0], then {4'h0, length-1} unless the request is address-only. A byte is held stable until tx_ready accepts it.
- R3: When request code bit 0 is 0 (a write) and the request is not address-only, length payload bytes follow the length byte. Message byte k is taken from the word at 0x54+4*(k/4), bits 8*(k%4)+7:8*(k%4).
- R4: An address-only request sends exactly three bytes, with no length byte and no payload.
- R5: Writing 1 to bit 0 of 0x74 starts a request. That bit reads back as 1 while the engine is busy and returns to 0 once the reply byte flagged rx_last has been taken, or once a timeout occurs.
- R6: Status bits 11:4 hold the first reply byte (the reply code). Bits 16:12 count all received reply bytes, header included, and saturate at 31.
- R7: For read requests (code bit 0 is 1), reply byte j (j ≥ 1) is stored as data byte j-1 in the read words at 0x64..0x70, packed little-endian as in R3. Data bytes beyond the sixteenth are dropped.
- R8: For write requests, the reply byte after the header is placed in status bits 24:17, where it reports how many bytes the sink accepted.
- R9: With the timer enabled (0x74 bit 2), if no reply byte is taken within L cycles after the last request byte is accepted (L = 0x74 bits 31:16), status bit 0 is set and the request ends. A reply byte presented in the L-th cycle is still accepted.
- R10: With the timer disabled, the engine waits for a reply without a time limit.
- R11: While busy, writes to the command and write-data words are ignored, and a further start request has no effect.
- R12: Writing 0 to bit 4 of 0x700 aborts any request, clears busy and the status, and holds the engine idle. Writing 1 to that bit releases the engine.
- R13: Starting a request clears the status word and the read words. Unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data returns on the next cycle |
| bus_addr | input | 12 | Byte offset, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tx_valid | output | 1 | Request byte valid |
| tx_ready | input | 1 | Sink accepts the request byte |
| tx_data | output | 8 | Request byte |
| rx_valid | input | 1 | Reply byte valid, taken without back-pressure |
| rx_data | input | 8 | Reply byte |
| rx_last | input | 1 | Marks the final reply byte |

## Verification
The assertions take for granted that the sink never presents a reply byte while the engine is still sending. They also assume that a soft reset is only applied while no request byte is waiting on the link. The stimulus follows both rules: every reply is sent only after the bench has seen the last expected request byte accepted, and the soft reset is issued only while the engine waits for a reply. The sink's ready signal stalls in a fixed pattern during some requests, so the assertion that a byte holds until accepted is exercised.

// File: rtl/aux_pkg.sv
// Shared definitions for the AUX transaction engine: register offsets,
// the command word layout and the engine state encoding.
package aux_pkg;

    localparam logic [11:0] OFS_CMD  = 12'h050;
    localparam logic [11:0] OFS_WD0  = 12'h054;
    localparam logic [11:0] OFS_RD0  = 12'h064;
    localparam logic [11:0] OFS_REQ  = 12'h074;
    localparam logic [11:0] OFS_STAT = 12'h078;
    localparam logic [11:0] OFS_RST  = 12'h700;

    // Command word as stored: bit 28 address-only, 27:8 address, 7:4 len-1, 3:0 code
    typedef struct packed {
        logic        addr_only;
        logic [19:0] addr;
        logic [3:0]  len_m1;
        logic [3:0]  code;
    } aux_cmd_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2,
        ST_RECV = 2'd3
    } eng_state_t;

endpackage

// File: rtl/aux_req_bytes.sv
// Request byte builder. Combinationally maps a byte index to the request
// byte and gives the total request length.
// Assumes the command and payload stay stable while a request is in flight.
module aux_req_bytes
    import aux_pkg::*;
#(
    parameter int WORDS = 4
) (
    input  aux_cmd_t               cmd,
    input  logic [WORDS-1:0][31:0] wr_words,
    input  logic [4:0]             idx,
    output logic [7:0]             byte_out,
    output logic [4:0]             total
);
    localparam int HDR = 3;

    logic [4:0] pidx;
    logic       has_payload;

    // Request length: header, optional length byte, optional payload
    always_comb begin
        has_payload = !cmd.addr_only && !cmd.code[0];
        total = 5'(HDR) + (cmd.addr_only ? 5'd0 : 5'd1)
              + (has_payload ? (5'(cmd.len_m1) + 5'd1) : 5'd0);
    end

    // Byte selection by index
    always_comb begin
        pidx = idx - 5'd4;
        case (idx)
            5'd0:    byte_out = {cmd.code, cmd.addr[19:16]};
            5'd1:    byte_out = cmd.addr[15:8];
            5'd2:    byte_out = cmd.addr[7:0];
            5'd3:    byte_out = {4'h0, cmd.len_m1};
            default: byte_out = wr_words[pidx[3:2]][{pidx[1:0], 3'b000} +: 8];
        endcase
    end

endmodule

// File: rtl/aux_link_fsm.sv
// Link sequencer. Sends the request bytes, runs the reply timer and
// captures the reply into the status fields and the read words.
// Assumes a reply is presented only after the request has been sent;
// rx bytes are taken without back-pressure.
module aux_link_fsm
    import aux_pkg::*;
#(
    parameter int WORDS = 4,
    parameter int TMO_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  aux_cmd_t               cmd,
    input  logic [WORDS-1:0][31:0] wr_words,
    input  logic                   tmr_en,
    input  logic [TMO_W-1:0]       tmo_limit,
    output logic                   tx_valid,
    input  logic                   tx_ready,
    output logic [7:0]             tx_data,
    input  logic                   rx_valid,
    input  logic [7:0]             rx_data,
    input  logic                   rx_last,
    output logic                   busy,
    output logic [31:0]            status_word,
    output logic [WORDS-1:0][31:0] rd_words
);
    localparam int BYTES = WORDS * 4;

    eng_state_t       state;
    logic [4:0]       tx_idx;
    logic [4:0]       total;
    logic [TMO_W-1:0] tmr;
    logic [4:0]       rx_cnt;
    logic [4:0]       didx;
    logic             tmo_flag;
    logic [7:0]       reply_code;
    logic [7:0]       extra;

    aux_req_bytes #(.WORDS(WORDS)) u_bytes (
        .cmd      (cmd),
        .wr_words (wr_words),
        .idx      (tx_idx),
        .byte_out (tx_data),
        .total    (total)
    );

    assign didx     = rx_cnt - 5'd1;
    assign tx_valid = (state == ST_SEND);
    assign busy     = (state != ST_IDLE);
    assign status_word = {7'b0, extra, rx_cnt, reply_code, 3'b0, tmo_flag};

    // Transaction sequencing, timer and reply capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            tx_idx     <= '0;
            tmr        <= '0;
            rx_cnt     <= '0;
            tmo_flag   <= 1'b0;
            reply_code <= '0;
            extra      <= '0;
            rd_words   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state      <= ST_SEND;
                        tx_idx     <= '0;
                        rx_cnt     <= '0;
                        tmo_flag   <= 1'b0;
                        reply_code <= '0;
                        extra      <= '0;
                        rd_words   <= '0;
                    end
                end
                ST_SEND: begin
                    if (tx_ready) begin
                        if (tx_idx == total - 5'd1) begin
                            state <= ST_WAIT;
                            tmr   <= '0;
                        end else begin
                            tx_idx <= tx_idx + 5'd1;
                        end
                    end
                end
                ST_WAIT: begin
                    if (rx_valid) begin
                        reply_code <= rx_data;
                        rx_cnt     <= 5'd1;
                        state      <= rx_last ? ST_IDLE : ST_RECV;
                    end else if (tmr_en && tmr == tmo_limit - 1'b1) begin
                        tmo_flag <= 1'b1;
                        state    <= ST_IDLE;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                ST_RECV: begin
                    if (rx_valid) begin
                        if (rx_cnt != 5'd31) rx_cnt <= rx_cnt + 5'd1;
                        if (cmd.code[0] && rx_cnt <= 5'(BYTES))
                            rd_words[didx[3:2]][{didx[1:0], 3'b000} +: 8] <= rx_data;
                        if (!cmd.code[0] && rx_cnt == 5'd1)
                            extra <= rx_data;
                        if (rx_last) state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/aux_regs.sv
// Register file. Holds the command, write payload and configuration,
// the soft-reset bit and the registered read mux.
// Assumes word-aligned offsets; unmapped offsets read as zero.
module aux_regs
    import aux_pkg::*;
#(
    parameter int                WORDS       = 4,
    parameter int                TMO_W       = 16,
    parameter logic [TMO_W-1:0]  TMO_RESET   = 64,
    parameter logic [4:0]        PULSE_RESET = 5'd9
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [11:0]            bus_addr,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    input  logic                   busy,
    input  logic [31:0]            status_word,
    input  logic [WORDS-1:0][31:0] rd_words,
    output aux_cmd_t               cmd,
    output logic [WORDS-1:0][31:0] wr_words,
    output logic                   start,
    output logic                   tmr_en,
    output logic [TMO_W-1:0]       tmo_limit,
    output logic                   eng_rst_bit
);
    logic       sync_sel;
    logic [4:0] pulse_cnt;
    logic [31:0] rmux;

    assign start = bus_wr && bus_addr == OFS_REQ && bus_wdata[0] && !busy && eng_rst_bit;

    // Command, configuration and soft-reset register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd         <= '0;
            sync_sel    <= 1'b0;
            tmr_en      <= 1'b0;
            pulse_cnt   <= PULSE_RESET;
            tmo_limit   <= TMO_RESET;
            eng_rst_bit <= 1'b1;
        end else if (bus_wr) begin
            if (bus_addr == OFS_CMD && !busy) cmd <= aux_cmd_t'(bus_wdata[28:0]);
            if (bus_addr == OFS_REQ) begin
                sync_sel  <= bus_wdata[1];
                tmr_en    <= bus_wdata[2];
                pulse_cnt <= bus_wdata[13:9];
                tmo_limit <= bus_wdata[16 +: TMO_W];
            end
            if (bus_addr == OFS_RST) eng_rst_bit <= bus_wdata[4];
        end
    end

    // One write-data word per generate slot
    for (genvar i = 0; i < WORDS; i++) begin : g_wd
        always_ff @(posedge clk) begin
            if (!rst_n) wr_words[i] <= '0;
            else if (bus_wr && !busy && bus_addr == OFS_WD0 + 12'(4 * i))
                wr_words[i] <= bus_wdata;
        end
    end

    // Read decode
    always_comb begin
        rmux = '0;
        case (bus_addr)
            OFS_CMD:  rmux = {3'b0, cmd};
            OFS_REQ:  rmux = {tmo_limit, 2'b00, pulse_cnt, 6'b0, tmr_en, sync_sel, busy};
            OFS_STAT: rmux = status_word;
            OFS_RST:  rmux = {27'b0, eng_rst_bit, 4'b0};
            default:  rmux = '0;
        endcase
        for (int i = 0; i < WORDS; i++) begin
            if (bus_addr == OFS_WD0 + 12'(4 * i)) rmux = wr_words[i];
            if (bus_addr == OFS_RD0 + 12'(4 * i)) rmux = rd_words[i];
        end
    end

    // Registered read data
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= bus_rd ? rmux : 32'h0;
    end

endmodule

// File: rtl/aux_xact_engine.sv
// Top of the AUX transaction engine: register file plus link sequencer.
// The soft-reset bit is combined with the chip reset to hold the
// sequencer idle. Assumes a single clock domain.
module aux_xact_engine
    import aux_pkg::*;
#(
    parameter int                WORDS       = 4,
    parameter int                TMO_W       = 16,
    parameter logic [TMO_W-1:0]  TMO_RESET   = 64,
    parameter logic [4:0]        PULSE_RESET = 5'd9
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic [7:0]  tx_data,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_last
);
    aux_cmd_t               cmd_q;
    logic [WORDS-1:0][31:0] wr_words;
    logic [WORDS-1:0][31:0] rd_words;
    logic                   start;
    logic                   tmr_en;
    logic [TMO_W-1:0]       tmo_limit;
    logic                   eng_rst_bit;
    logic                   eng_rst_n;
    logic                   busy;
    logic [31:0]            status_word;

    assign eng_rst_n = rst_n & eng_rst_bit;

    aux_regs #(
        .WORDS(WORDS), .TMO_W(TMO_W), .TMO_RESET(TMO_RESET), .PULSE_RESET(PULSE_RESET)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy(busy), .status_word(status_word), .rd_words(rd_words),
        .cmd(cmd_q), .wr_words(wr_words), .start(start), .tmr_en(tmr_en),
        .tmo_limit(tmo_limit), .eng_rst_bit(eng_rst_bit)
    );

    aux_link_fsm #(.WORDS(WORDS), .TMO_W(TMO_W)) u_fsm (
        .clk(clk), .rst_n(eng_rst_n), .start(start), .cmd(cmd_q),
        .wr_words(wr_words), .tmr_en(tmr_en), .tmo_limit(tmo_limit),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .busy(busy), .status_word(status_word), .rd_words(rd_words)
    );

endmodule

// File: rtl/aux_xact_checker.sv
// Property checker for the AUX transaction engine, bound to the top.
module aux_xact_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic [7:0]  tx_data,
    input logic        busy,
    input logic        eng_rst_n,
    input logic [28:0] cmd_bits,
    input logic [31:0] wd0,
    input logic [31:0] status_word
);
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R2

    AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cmd_bits) && $stable(wd0)); // R11

    AST_TMO_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_word[0]) |-> !busy); // R9

    AST_SOFT_RST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_rst_n |=> !busy); // R12

    AST_START_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> status_word == 32'h0); // R13

endmodule

bind aux_xact_engine aux_xact_checker u_chk (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .busy(busy), .eng_rst_n(eng_rst_n),
    .cmd_bits(cmd_q), .wd0(wr_words[0]), .status_word(status_word)
);

// File: tb/aux_xact_engine_test.sv
// Self-checking bench with a behavioural reference model of the request
// stream and the resulting register contents.
module aux_xact_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_valid, tx_ready, rx_valid = 1'b0, rx_last = 1'b0;
    logic [7:0]  tx_data, rx_data = '0;

    integer checks = 0, fails = 0;
    logic [7:0] exp_tx[$];
    logic [7:0] got[$];
    logic [7:0] reply_q[$];
    logic [7:0] pay[16];
    logic [3:0] rdy_cnt = '0;
    logic       stall = 1'b0;
    bit         finished = 1'b0;

    localparam logic [31:0] CFG = 32'h0014_1204; // L=20, timer on, pulse 9
    localparam int L = 20;

    aux_xact_engine uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last)
    );

    always #4 clk = ~clk;

    always @(posedge clk) rdy_cnt <= rdy_cnt + 4'd1;
    assign tx_ready = stall ? (rdy_cnt[1:0] != 2'b00) : 1'b1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Per-clock compare of each accepted request byte against the model (R2 R3 R4)
    always @(negedge clk) begin
        if (rst_n && tx_valid && tx_ready) begin
            if (got.size() < exp_tx.size())
                chk("R2/R3/R4 tx byte", {24'h0, tx_data}, {24'h0, exp_tx[got.size()]});
            else
                chk("R4 extra tx byte", 32'h1, 32'h0);
            got.push_back(tx_data);
        end
    end

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    endtask

    task automatic start_txn(input logic [3:0] code, input logic [19:0] addr,
                             input logic [3:0] lm1, input logic aonly, input logic [31:0] cfg);
        exp_tx.delete(); got.delete();
        exp_tx.push_back({code, addr[19:16]});
        exp_tx.push_back(addr[15:8]);
        exp_tx.push_back(addr[7:0]);
        if (!aonly) exp_tx.push_back({4'h0, lm1});
        if (!aonly && !code[0])
            for (int k = 0; k <= int'(lm1); k++) exp_tx.push_back(pay[k]);
        for (int w = 0; w < 4; w++)
            bus_write(12'h054 + 12'(4 * w), {pay[4*w+3], pay[4*w+2], pay[4*w+1], pay[4*w]});
        bus_write(12'h050, {3'b0, aonly, addr, lm1, code});
        bus_write(12'h074, cfg | 32'h1);
    endtask

    task automatic wait_sent();
        int n = 0;
        while (got.size() < exp_tx.size() && n < 500) begin @(posedge clk); n++; end
    endtask

    task automatic send_reply(input int delay);
        repeat (delay) @(negedge clk);
        for (int i = 0; i < reply_q.size(); i++) begin
            rx_valid = 1'b1; rx_data = reply_q[i]; rx_last = (i == reply_q.size() - 1);
            @(negedge clk);
        end
        rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        logic [31:0] r;
        int n = 0;
        bus_read(12'h074, r);
        while (r[0] && n < 200) begin bus_read(12'h074, r); n++; end
        chk(req, {31'h0, r[0]}, 32'h0);
    endtask

    function automatic logic [31:0] exp_status(input logic tmo, input logic is_read);
        int cnt = reply_q.size() > 31 ? 31 : reply_q.size();
        logic [7:0] ex = (!is_read && reply_q.size() > 1) ? reply_q[1] : 8'h0;
        logic [7:0] rc = (reply_q.size() > 0) ? reply_q[0] : 8'h0;
        return {7'b0, ex, 5'(cnt), rc, 3'b0, tmo};
    endfunction

    function automatic logic [31:0] exp_rd(input int w, input logic is_read);
        logic [31:0] v = '0;
        for (int j = 1; j < reply_q.size(); j++)
            if (is_read && j <= 16 && (j - 1) / 4 == w)
                v[8*((j-1)%4) +: 8] = reply_q[j];
        return v;
    endfunction

    task automatic check_result(input string req, input logic tmo, input logic is_read);
        logic [31:0] r;
        bus_read(12'h078, r);
        chk({req, " status"}, r, exp_status(tmo, is_read));
        for (int w = 0; w < 4; w++) begin
            bus_read(12'h064 + 12'(4 * w), r);
            chk({req, " R7 read word"}, r, exp_rd(w, is_read));
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        for (int k = 0; k < 16; k++) pay[k] = 8'hA0 + 8'(k * 7);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        bus_read(12'h050, r); chk("R1 cmd", r, 32'h0);
        bus_read(12'h074, r); chk("R1 req", r, 32'h0040_1200);
        bus_read(12'h078, r); chk("R1 status", r, 32'h0);
        bus_read(12'h700, r); chk("R1 rst", r, 32'h10);
        bus_read(12'h064, r); chk("R1 rd0", r, 32'h0);
        // R13 unmapped offset
        bus_read(12'h3F0, r); chk("R13 unmapped", r, 32'h0);

        // R2 R3 R5 R6 R8: native write of 5 bytes, stalling sink
        stall = 1'b1;
        start_txn(4'h8, 20'h12345, 4'd4, 1'b0, CFG);
        bus_read(12'h074, r); chk("R5 busy", {31'h0, r[0]}, 32'h1);
        wait_sent(); stall = 1'b0;
        chk("R3 tx count", got.size(), 32'd9);
        reply_q = '{8'h00};
        send_reply(2);
        wait_idle("R5 self clear");
        check_result("R6", 1'b0, 1'b0);

        // R7: native read of 6 bytes
        start_txn(4'h9, 20'h00102, 4'd5, 1'b0, CFG);
        wait_sent();
        chk("R2 read tx count", got.size(), 32'd4);
        reply_q = '{8'h00, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
        send_reply(3);
        wait_idle("R5 read done");
        check_result("R7 read6", 1'b0, 1'b1);

        // R7 boundary: 16-byte read plus one excess byte that must be dropped
        start_txn(4'h9, 20'hFFFFF, 4'd15, 1'b0, CFG);
        wait_sent();
        reply_q = '{};
        reply_q.push_back(8'h00);
        for (int k = 0; k < 17; k++) reply_q.push_back(8'h30 + 8'(k));
        send_reply(1);
        wait_idle("R5 read16 done");
        check_result("R7 read16", 1'b0, 1'b1);

        // R13: a new start clears the read words
        start_txn(4'h0, 20'h00050, 4'd0, 1'b1, CFG);
        wait_sent();
        bus_read(12'h064, r); chk("R13 rd cleared", r, 32'h0);
        // R4: address-only request
        chk("R4 addr-only count", got.size(), 32'd3);
        reply_q = '{8'h00};
        send_reply(1);
        wait_idle("R4 done");
        check_result("R4", 1'b0, 1'b0);

        // R8: I2C write, partial acceptance
        start_txn(4'h4, 20'h00050, 4'd3, 1'b0, CFG);
        wait_sent();
        chk("R3 i2c tx count", got.size(), 32'd8);
        reply_q = '{8'h10, 8'h02};
        send_reply(2);
        wait_idle("R8 done");
        check_result("R8 partial", 1'b0, 1'b0);

        // R9: no reply -> timeout
        start_txn(4'h9, 20'h00200, 4'd0, 1'b0, CFG);
        wait_sent();
        reply_q = '{};
        wait_idle("R9 timeout end");
        check_result("R9 timeout", 1'b1, 1'b1);

        // R9 boundary: reply in the L-th cycle is accepted
        start_txn(4'h9, 20'h00201, 4'd0, 1'b0, CFG);
        wait_sent();
        reply_q = '{8'h00, 8'h5A};
        send_reply(L);
        wait_idle("R9 boundary end");
        check_result("R9 boundary", 1'b0, 1'b1);

        // R10: timer disabled, late reply still taken
        start_txn(4'h9, 20'h00202, 4'd0, 1'b0, CFG & ~32'h4);
        wait_sent();
        reply_q = '{8'h00, 8'hC3};
        send_reply(L + 40);
        wait_idle("R10 end");
        check_result("R10 no timer", 1'b0, 1'b1);

        // R11: writes and a second start while busy are ignored
        start_txn(4'h8, 20'h00303, 4'd1, 1'b0, CFG & ~32'h4);
        wait_sent();
        bus_write(12'h050, 32'h0ABCDE71);
        bus_write(12'h054, 32'hDEADBEEF);
        bus_write(12'h074, (CFG & ~32'h4) | 32'h1);
        reply_q = '{8'h00};
        send_reply(1);
        wait_idle("R11 end");
        bus_read(12'h050, r); chk("R11 cmd kept", r, {3'b0, 1'b0, 20'h00303, 4'd1, 4'h8});
        bus_read(12'h054, r); chk("R11 wd0 kept", r, {pay[3], pay[2], pay[1], pay[0]});
        repeat (10) @(negedge clk);
        chk("R11 no restart", got.size(), exp_tx.size());

        // R12: soft reset during wait
        start_txn(4'h9, 20'h00404, 4'd0, 1'b0, CFG & ~32'h4);
        wait_sent();
        bus_write(12'h700, 32'h0);
        bus_read(12'h074, r); chk("R12 busy cleared", {31'h0, r[0]}, 32'h0);
        bus_read(12'h078, r); chk("R12 status cleared", r, 32'h0);
        bus_write(12'h074, CFG | 32'h1);
        bus_read(12'h074, r); chk("R12 held idle", {31'h0, r[0]}, 32'h0);
        bus_write(12'h700, 32'h10);
        bus_read(12'h700, r); chk("R12 released", r, 32'h10);
        start_txn(4'h9, 20'h00405, 4'd0, 1'b0, CFG);
        wait_sent();
        reply_q = '{8'h00, 8'h77};
        send_reply(1);
        wait_idle("R12 after release");
        check_result("R12 after release", 1'b0, 1'b1);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule